// File: doc/BRIEF.md
# Banked Indexed Configuration Register Space

This block is a byte-wide configuration space that a host reaches through just two locations. Writing location 0 loads an index register. Reading or writing location 1 then reads or writes the configuration register that the index names. A read therefore takes two accesses: an index write, then a data read. A write also takes two accesses: an index write, then a data write.

A device-select register picks one of fifteen logical devices. That choice swaps in the bank of per-device registers seen at the device indices. Each bank has an enable bit and a 16-bit I/O base address. The general-purpose pin device (number 7) adds three more registers:
- a pin selector;
- a per-pin drive configuration byte;
- a per-pin event byte.

Every device's enable and base address is driven out as a plain output. So is each pin's 3-bit drive configuration, and logic elsewhere on the chip uses these values to steer decoding and pads.

Host accesses travel as a valid/ready request stream. Read results return on a valid/ready response stream. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Only one read can be outstanding. `req_ready` stays low from the edge that takes a read until the edge where its response is taken (`rsp_valid` and `rsp_ready` both high). Writes produce no response.

Top module: `idx_cfg_space`

## Requirements
- R1: A request write to location 0 (`req_addr`=0) loads the index register. A read of location 0 returns the current index.
- R2: Index 0x20 reads 0xE9, the chip identity. Index 0x27 reads the revision byte (default 0x01). Writes to either index change nothing.
- R3: Index 0x07 is the device-select register. It accepts values 0x00 to 0x0E and reads them back. A write of any larger value is ignored and the old value is kept.
- R4: Index 0x30 holds the enable of the selected device in bit 0. Reads return 0 in bits 7..1. Device n's enable appears on `dev_enable[n]`.
- R5: Index 0x60 holds bits 15..8 and index 0x61 holds bits 7..0 of the selected device's base address. Device n's base appears on `dev_base[16n+15:16n]`. Each device keeps its own values.
- R6: While device 7 is selected, index 0xF0 is the pin selector and reads back the byte last written. The selected pin is 8*bits[7:4] + bits[2:0]. The selection is valid only when bit 3 is 0 and the pin is below 29.
- R7: While device 7 is selected and the pin selection is valid, index 0xF1 is that pin's drive configuration. Bit 0 is output enable, bit 1 is push-pull (0 = open-drain) and bit 2 is pull-up. Bits 7..3 read 0. Pin p's bits appear on `pin_cfg[3p+2:3p]` in the same order.
- R8: While device 7 is selected and the pin selection is valid, index 0xF2 is a full 8-bit event byte kept separately for each pin.
- R9: When the pin selection is invalid, writes to 0xF1 or 0xF2 change nothing and reads of them return 0.
- R10: Reads of indices with no register in the current bank return 0, and writes to them change nothing. This includes 0xF0 to 0xF2 while a device other than 7 is selected.
- R11: After reset, the following all read 0: the index, the device select, every enable, every base, the pin selector, every pin configuration and every event byte.
- R12: A read taken at a clock edge raises `rsp_valid` after that edge with data sampled at the edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 1 | 0 = index location, 1 = data window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| dev_enable | output | 15 | Per-device enable bits |
| dev_base | output | 240 | Per-device 16-bit base addresses, device n at bits 16n+15:16n |
| pin_cfg | output | 87 | Per-pin {pull-up, push-pull, output enable} |

## Verification
A bank decode that picks the wrong device, or a pin write that lands on the wrong entry, changes the exported `dev_enable`, `dev_base` or `pin_cfg` one cycle after the data write is taken. The bench model compares these outputs on every clock, so such an error shows at once rather than only when the register is read back. A corrupt index or device select shows on the next read response, one cycle after the read is taken. A handshake fault shows as `rsp_data` changing during a stall or `req_ready` rising too early. The bench holds `rsp_ready` low for several cycles to expose this.

// File: rtl/icfg_pkg.sv
package icfg_pkg;
  localparam logic [7:0] IX_DEVSEL = 8'h07;
  localparam logic [7:0] IX_IDENT  = 8'h20;
  localparam logic [7:0] IX_REVIS  = 8'h27;
  localparam logic [7:0] IX_ENABLE = 8'h30;
  localparam logic [7:0] IX_BASEHI = 8'h60;
  localparam logic [7:0] IX_BASELO = 8'h61;
  localparam logic [7:0] IX_PINSEL = 8'hF0;
  localparam logic [7:0] IX_PINCFG = 8'hF1;
  localparam logic [7:0] IX_PINEVT = 8'hF2;

  typedef struct packed {
    logic       we;
    logic [7:0] idx;
    logic [7:0] data;
  } cfg_wr_t;
endpackage

// File: rtl/icfg_host_port.sv
module icfg_host_port
  import icfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_addr,
  input  logic       req_write,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  input  logic [7:0] win_rdata,
  output logic [7:0] cur_idx,
  output cfg_wr_t    win_wr
);
  logic       take;
  logic       rv_q;
  logic [7:0] rd_q;
  logic [7:0] idx_q;

  assign req_ready = !rv_q;
  assign take      = req_valid && req_ready;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign cur_idx   = idx_q;

  assign win_wr.we   = take && req_write && req_addr;
  assign win_wr.idx  = idx_q;
  assign win_wr.data = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (take && req_write && !req_addr) idx_q <= req_wdata;
      if (take && !req_write) begin
        rv_q <= 1'b1;
        rd_q <= req_addr ? win_rdata : idx_q;
      end else if (rv_q && rsp_ready) begin
        rv_q <= 1'b0;
      end
    end
  end

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && !req_ready));

  // R12
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

// File: rtl/icfg_dev_bank.sv
module icfg_dev_bank
  import icfg_pkg::*;
#(
  parameter int NUM_DEV = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cfg_wr_t               win_wr,
  input  logic [7:0]            cur_idx,
  output logic [7:0]            sel_dev,
  output logic [7:0]            rdata,
  output logic [NUM_DEV-1:0]    dev_enable,
  output logic [NUM_DEV*16-1:0] dev_base
);
  logic [7:0]  sel_q;
  logic        act_q  [NUM_DEV];
  logic [15:0] base_q [NUM_DEV];

  assign sel_dev = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (win_wr.we && win_wr.idx == IX_DEVSEL &&
                 win_wr.data < 8'(NUM_DEV)) begin
      sel_q <= win_wr.data;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = win_wr.we && (sel_q == 8'(d));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[d]  <= 1'b0;
        base_q[d] <= '0;
      end else if (hit) begin
        if (win_wr.idx == IX_ENABLE) act_q[d] <= win_wr.data[0];
        if (win_wr.idx == IX_BASEHI) base_q[d][15:8] <= win_wr.data;
        if (win_wr.idx == IX_BASELO) base_q[d][7:0]  <= win_wr.data;
      end
    end
    assign dev_enable[d]        = act_q[d];
    assign dev_base[16*d +: 16] = base_q[d];
  end

  always_comb begin
    logic        a;
    logic [15:0] b;
    a = 1'b0;
    b = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (sel_q == 8'(d)) begin
        a = act_q[d];
        b = base_q[d];
      end
    end
    case (cur_idx)
      IX_DEVSEL: rdata = sel_q;
      IX_ENABLE: rdata = {7'b0, a};
      IX_BASEHI: rdata = b[15:8];
      IX_BASELO: rdata = b[7:0];
      default:   rdata = 8'h00;
    endcase
  end

  // R3
  devsel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q < 8'(NUM_DEV));

  // R4
  enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr.we |=> $stable(dev_enable));
endmodule

// File: rtl/icfg_pin_bank.sv
module icfg_pin_bank
  import icfg_pkg::*;
#(
  parameter int NUM_PINS = 29
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cfg_wr_t               win_wr,
  input  logic [7:0]            cur_idx,
  input  logic                  bank_on,
  output logic [7:0]            rdata,
  output logic [NUM_PINS*3-1:0] pin_cfg
);
  logic [7:0] psel_q;
  logic [6:0] pin_num;
  logic       pin_ok;
  logic [2:0] cfg_q [NUM_PINS];
  logic [7:0] evt_q [NUM_PINS];

  assign pin_num = {psel_q[7:4], psel_q[2:0]};
  assign pin_ok  = !psel_q[3] && (pin_num < 7'(NUM_PINS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel_q <= '0;
    end else if (win_wr.we && bank_on && win_wr.idx == IX_PINSEL) begin
      psel_q <= win_wr.data;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = win_wr.we && bank_on && pin_ok && (pin_num == 7'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[p] <= '0;
        evt_q[p] <= '0;
      end else if (hit) begin
        if (win_wr.idx == IX_PINCFG) cfg_q[p] <= win_wr.data[2:0];
        if (win_wr.idx == IX_PINEVT) evt_q[p] <= win_wr.data;
      end
    end
    assign pin_cfg[3*p +: 3] = cfg_q[p];
  end

  always_comb begin
    logic [2:0] c;
    logic [7:0] e;
    c = '0;
    e = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_ok && pin_num == 7'(p)) begin
        c = cfg_q[p];
        e = evt_q[p];
      end
    end
    rdata = 8'h00;
    if (bank_on) begin
      case (cur_idx)
        IX_PINSEL: rdata = psel_q;
        IX_PINCFG: rdata = {5'b0, c};
        IX_PINEVT: rdata = e;
        default:   rdata = 8'h00;
      endcase
    end
  end

  // R9
  bad_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr.we && !pin_ok) |=> $stable(pin_cfg));

  // R10
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr.we && !bank_on) |=> ($stable(pin_cfg) && $stable(psel_q)));
endmodule

// File: rtl/idx_cfg_space.sv
module idx_cfg_space
  import icfg_pkg::*;
#(
  parameter int         NUM_DEV  = 15,
  parameter int         PIN_DEV  = 7,
  parameter int         NUM_PINS = 29,
  parameter logic [7:0] IDENT    = 8'hE9,
  parameter logic [7:0] REVISION = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_addr,
  input  logic                  req_write,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_data,
  output logic [NUM_DEV-1:0]    dev_enable,
  output logic [NUM_DEV*16-1:0] dev_base,
  output logic [NUM_PINS*3-1:0] pin_cfg
);
  cfg_wr_t    win_wr;
  logic [7:0] cur_idx;
  logic [7:0] sel_dev;
  logic [7:0] dev_rd;
  logic [7:0] pin_rd;
  logic [7:0] win_rdata;
  logic       pin_bank_on;

  assign pin_bank_on = (sel_dev == 8'(PIN_DEV));

  icfg_host_port u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .win_rdata(win_rdata), .cur_idx(cur_idx), .win_wr(win_wr)
  );

  icfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_dev (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .cur_idx(cur_idx),
    .sel_dev(sel_dev), .rdata(dev_rd),
    .dev_enable(dev_enable), .dev_base(dev_base)
  );

  icfg_pin_bank #(.NUM_PINS(NUM_PINS)) u_pin (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .cur_idx(cur_idx),
    .bank_on(pin_bank_on), .rdata(pin_rd), .pin_cfg(pin_cfg)
  );

  always_comb begin
    case (cur_idx)
      IX_IDENT: win_rdata = IDENT;
      IX_REVIS: win_rdata = REVISION;
      default:  win_rdata = dev_rd | pin_rd;
    endcase
  end
endmodule

// File: tb/sim_idx_cfg_space.sv
`timescale 1ns/1ps
module sim_idx_cfg_space;
  localparam int ND = 15;
  localparam int NP = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_addr = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [ND-1:0] dev_enable;
  logic [ND*16-1:0] dev_base;
  logic [NP*3-1:0] pin_cfg;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  idx_cfg_space u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .dev_enable(dev_enable), .dev_base(dev_base), .pin_cfg(pin_cfg)
  );

  // reference model state
  int m_idx, m_dev, m_psel, m_rd;
  bit m_rv;
  bit m_act [ND];
  int m_base [ND];
  int m_cfg [NP];
  int m_evt [NP];

  function automatic int pin_of(int s);
    int p;
    if ((s & 8) != 0) return -1;
    p = (s >> 4) * 8 + (s & 7);
    if (p >= NP) return -1;
    return p;
  endfunction

  function automatic int m_read(bit a);
    int p;
    if (!a) return m_idx;
    p = pin_of(m_psel);
    case (m_idx)
      'h20: return 'hE9;
      'h27: return 'h01;
      'h07: return m_dev;
      'h30: return int'(m_act[m_dev]);
      'h60: return (m_base[m_dev] >> 8) & 'hFF;
      'h61: return m_base[m_dev] & 'hFF;
      'hF0: return (m_dev == 7) ? m_psel : 0;
      'hF1: return (m_dev == 7 && p >= 0) ? m_cfg[p] : 0;
      'hF2: return (m_dev == 7 && p >= 0) ? m_evt[p] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(int d);
    int p;
    p = pin_of(m_psel);
    case (m_idx)
      'h07: if (d < ND) m_dev = d;
      'h30: m_act[m_dev] = d[0];
      'h60: m_base[m_dev] = (m_base[m_dev] & 'hFF) | (d << 8);
      'h61: m_base[m_dev] = (m_base[m_dev] & 'hFF00) | d;
      'hF0: if (m_dev == 7) m_psel = d;
      'hF1: if (m_dev == 7 && p >= 0) m_cfg[p] = d & 7;
      'hF2: if (m_dev == 7 && p >= 0) m_evt[p] = d;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_dev = 0; m_psel = 0; m_rd = 0; m_rv = 0;
      for (int i = 0; i < ND; i++) begin m_act[i] = 0; m_base[i] = 0; end
      for (int i = 0; i < NP; i++) begin m_cfg[i] = 0; m_evt[i] = 0; end
    end else if (m_rv) begin
      if (rsp_ready) m_rv = 0;
    end else if (req_valid) begin
      if (req_write) begin
        if (!req_addr) m_idx = int'(req_wdata);
        else m_write(int'(req_wdata));
      end else begin
        m_rv = 1;
        m_rd = m_read(req_addr);
      end
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      logic [ND-1:0] e_en;
      logic [ND*16-1:0] e_base;
      logic [NP*3-1:0] e_cfg;
      for (int i = 0; i < ND; i++) begin
        e_en[i] = m_act[i];
        e_base[16*i +: 16] = 16'(m_base[i]);
      end
      for (int i = 0; i < NP; i++) e_cfg[3*i +: 3] = 3'(m_cfg[i]);
      check(rsp_valid == m_rv && req_ready == !m_rv, "R12 handshake",
            {rsp_valid, req_ready}, {m_rv, !m_rv});
      if (m_rv) check(rsp_data == 8'(m_rd), "R12 model data", rsp_data, m_rd);
      check(dev_enable == e_en, "R4 dev_enable", dev_enable, e_en);
      check(dev_base == e_base, "R5 dev_base", dev_base[63:0], e_base[63:0]);
      check(pin_cfg == e_cfg, "R7 pin_cfg", pin_cfg, e_cfg);
    end
  end

  task automatic wr(bit a, int d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = 8'(d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic reg_wr(int ix, int d);
    wr(0, ix);
    wr(1, d);
  endtask

  task automatic rd(bit a, int exp, string tag, int stall = 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; rsp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_data == 8'(exp), tag, rsp_data, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_data == 8'(exp), "R12 stall hold",
            rsp_data, exp);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic reg_rd(int ix, int exp, string tag);
    wr(0, ix);
    rd(1, exp, tag);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check(dev_enable == '0, "R11 enables at reset", dev_enable, 0);
    check(dev_base == '0, "R11 bases at reset", dev_base[63:0], 0);
    check(pin_cfg == '0, "R11 pins at reset", pin_cfg, 0);
    rd(0, 0, "R11 index at reset");
    reg_rd('h07, 0, "R11 devsel at reset");
    // R2 identity and revision, read-only
    reg_rd('h20, 'hE9, "R2 ident");
    reg_rd('h27, 'h01, "R2 revision");
    reg_wr('h20, 'h11);
    reg_rd('h20, 'hE9, "R2 ident write ignored");
    // R1 index register
    wr(0, 'h5A);
    rd(0, 'h5A, "R1 index readback");
    // R3 device select
    reg_wr('h07, 3);
    reg_rd('h07, 3, "R3 devsel 3");
    reg_wr('h07, 'h0F);
    reg_rd('h07, 3, "R3 devsel out of range ignored");
    // R4/R5 per-device bank
    reg_wr('h30, 'hFF);
    reg_rd('h30, 'h01, "R4 enable bit only");
    reg_wr('h60, 'h12);
    reg_wr('h61, 'h34);
    check(dev_enable == 15'h0008, "R4 enable output dev3", dev_enable, 15'h0008);
    check(dev_base[48 +: 16] == 16'h1234, "R5 base output dev3", dev_base[48 +: 16], 16'h1234);
    reg_wr('h07, 'h0E);
    reg_rd('h30, 0, "R4 dev14 independent");
    reg_wr('h60, 'hAB);
    reg_wr('h61, 'hCD);
    check(dev_base[224 +: 16] == 16'hABCD, "R5 base output dev14", dev_base[224 +: 16], 16'hABCD);
    reg_wr('h07, 3);
    reg_rd('h61, 'h34, "R5 dev3 base low kept");
    reg_rd('h60, 'h12, "R5 dev3 base high kept");
    // R10 unimplemented and off-bank indices
    reg_wr('h31, 'h77);
    reg_rd('h31, 0, "R10 unimplemented index");
    reg_wr('hF0, 'h25);
    reg_rd('hF0, 0, "R10 pinsel outside pin bank");
    reg_wr('h07, 7);
    reg_rd('hF0, 0, "R10 pinsel unchanged by off-bank write");
    // R6 pin select
    reg_wr('hF0, 'h25);
    reg_rd('hF0, 'h25, "R6 pinsel readback");
    // R7 pin config (pin 21)
    reg_wr('hF1, 'hFF);
    reg_rd('hF1, 'h07, "R7 cfg bits 2..0 only");
    check(pin_cfg[63 +: 3] == 3'b111, "R7 pin21 output", pin_cfg[63 +: 3], 7);
    reg_wr('hF0, 'h00);
    reg_wr('hF1, 'h05);
    check(pin_cfg[0 +: 3] == 3'b101, "R7 pin0 output", pin_cfg[0 +: 3], 5);
    reg_wr('hF0, 'h34);
    reg_wr('hF1, 'h02);
    check(pin_cfg[84 +: 3] == 3'b010, "R7 pin28 output", pin_cfg[84 +: 3], 2);
    // R8 event byte
    reg_wr('hF0, 'h25);
    reg_wr('hF2, 'hA5);
    reg_rd('hF2, 'hA5, "R8 pin21 event");
    reg_wr('hF0, 'h00);
    reg_rd('hF2, 0, "R8 pin0 event separate");
    // R9 invalid pin selections
    reg_wr('hF0, 'h35);
    reg_wr('hF1, 'h07);
    reg_wr('hF2, 'h3C);
    reg_rd('hF1, 0, "R9 pin29 cfg reads 0");
    reg_rd('hF2, 0, "R9 pin29 event reads 0");
    reg_wr('hF0, 'h08);
    reg_wr('hF1, 'h07);
    reg_rd('hF1, 0, "R9 bit3 set reads 0");
    check(pin_cfg[0 +: 3] == 3'b101, "R9 pin0 untouched", pin_cfg[0 +: 3], 5);
    // R12 back-pressure
    wr(0, 'h20);
    rd(1, 'hE9, "R12 stalled read", 4);
    rd(0, 'h20, "R12 read after stall");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule